// File: doc/BRIEF.md
# I/O Expander Transaction Sequencer

This block turns a single request strobe into a complete one-byte exchange with an 8-bit quasi-bidirectional I/O expander on a two-wire serial bus. It does not touch the bus lines itself. Instead it issues a series of commands to a bit-level bus-master engine: start, transmit byte, receive byte, acknowledge slot and stop. It waits for the engine to report each command complete before it issues the next one.

For a write, the sequencer forms the address byte from a fixed 4-bit group code and a 3-bit strap address. It then sends the output pattern ORed with a direction mask. This keeps every pin marked as an input released high, because a pin written as 0 is held low and always reads back as zero. For a read, it sends the address with the read flag set, receives one byte and returns it as the read pattern. In both cases the master leaves the data line released in every acknowledge slot, and the slave's acknowledge level plays no part.

Top module: `iox_seq`

## Requirements
- R1: After reset, `busy`, `done` and `cmd_valid` are 0 and `rd_pat` is 0x00.
- R2: A write issues these commands in order: START, TX, SLOT, TX, SLOT, STOP. The `cmd_op` codes are START=0, TX=1, RX=2, SLOT=3 and STOP=4.
- R3: A read issues these commands in order: START, TX, SLOT, RX, SLOT, STOP.
- R4: The address byte on the first TX has the group code 0100 in bits 7:4 and `strap` in bits 3:1. Bit 0 is 0 for a write and 1 for a read.
- R5: The data byte on the second TX of a write is `wr_pat | in_mask`, bit by bit. A mask bit of 1 marks an input pin and forces that pin to 1.
- R6: `strap`, `wr_pat` and `in_mask` are sampled on the cycle a request is accepted. Changing them during a transaction does not alter the bytes sent.
- R7: `cmd_valid` stays high with `cmd_op` and `cmd_byte` unchanged until `cmd_done` is seen. Each such `cmd_done` advances exactly one command. A `cmd_done` while `cmd_valid` is low is ignored.
- R8: The `slot_ack` input has no effect on the commands issued or on the outcome.
- R9: `rd_pat` takes the byte presented on `rx_byte` when the RX command completes. It changes only at the end of a read, in the cycle `done` is high. Writes leave it unchanged.
- R10: A request that arrives while `busy` is high is ignored. When `wr_req` and `rd_req` arrive together in idle, the write is performed.
- R11: The clock edge that completes STOP drops `busy` and raises `done` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap | input | 3 | Expander strap address |
| wr_pat | input | 8 | Pattern to drive on the expander pins |
| in_mask | input | 8 | Pins used as inputs (1 = input, forced high) |
| wr_req | input | 1 | Write transaction request strobe |
| rd_req | input | 1 | Read transaction request strobe |
| rd_pat | output | 8 | Last pattern read from the expander |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| cmd_valid | output | 1 | Command presented to the bus master |
| cmd_op | output | 3 | Command code (START=0, TX=1, RX=2, SLOT=3, STOP=4) |
| cmd_byte | output | 8 | Byte for a TX command, 0 otherwise |
| cmd_done | input | 1 | Bus master finished the current command |
| rx_byte | input | 8 | Byte received by the bus master |
| slot_ack | input | 1 | Level seen in an acknowledge slot (not used) |

## Verification
A wrong step counter shows up on `cmd_op` at the first command after the fault. It appears as a skipped or repeated slot, or as RX where TX belongs, and is visible before the engine's next completion. A corrupt latched address or data register appears on `cmd_byte` in the same cycle its TX command is issued. A capture fault in the read path stays hidden until `done`, when `rd_pat` is sampled against the received byte. A restart caused by a late or ignored request appears as `busy` remaining high one cycle after the done pulse.

// File: rtl/iox_pkg.sv
package iox_pkg;

    typedef enum logic [2:0] {
        OP_START = 3'd0,
        OP_TX    = 3'd1,
        OP_RX    = 3'd2,
        OP_SLOT  = 3'd3,
        OP_STOP  = 3'd4
    } bus_op_e;

    localparam int unsigned OP_W = 3;

endpackage

// File: rtl/iox_frame_builder.sv
module iox_frame_builder #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned STRAP_W    = 3,
    parameter int unsigned GROUP_W    = 4,
    parameter logic [GROUP_W-1:0] GROUP_CODE = 4'b0100
) (
    input  logic [STRAP_W-1:0] strap,
    input  logic [DATA_W-1:0]  pat,
    input  logic [DATA_W-1:0]  mask,
    output logic [DATA_W-1:0]  addr_wr,
    output logic [DATA_W-1:0]  addr_rd,
    output logic [DATA_W-1:0]  data_out
);

    localparam int unsigned HEAD_W = GROUP_W + STRAP_W;

    logic [HEAD_W-1:0] head;

    assign head    = {GROUP_CODE, strap};
    assign addr_wr = {head, 1'b0};
    assign addr_rd = {head, 1'b1};

    for (genvar b = 0; b < DATA_W; b++) begin : g_release
        assign data_out[b] = pat[b] | mask[b];
    end

endmodule

// File: rtl/iox_step_ctrl.sv
module iox_step_ctrl
    import iox_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] addr_wr,
    input  logic [DATA_W-1:0] addr_rd,
    input  logic [DATA_W-1:0] data_in,
    input  logic              cmd_done,
    output logic              cmd_valid,
    output logic [OP_W-1:0]   cmd_op,
    output logic [DATA_W-1:0] cmd_byte,
    output logic              busy,
    output logic              done,
    output logic              rx_take,
    output logic              fin_rd
);

    localparam int unsigned STEP_CNT  = 6;
    localparam int unsigned STEP_W    = $clog2(STEP_CNT);
    localparam logic [STEP_W-1:0] S_ADDR = STEP_W'(1);
    localparam logic [STEP_W-1:0] S_BODY = STEP_W'(3);
    localparam logic [STEP_W-1:0] S_LAST = STEP_W'(STEP_CNT - 1);

    typedef struct packed {
        logic              run;
        logic [STEP_W-1:0] step;
        logic              is_rd;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              done;
    } ctrl_t;

    ctrl_t   st_d, st_q;
    bus_op_e op_now;
    logic    adv;

    always_comb begin
        unique case (st_q.step)
            STEP_W'(0): op_now = OP_START;
            STEP_W'(1): op_now = OP_TX;
            STEP_W'(2): op_now = OP_SLOT;
            STEP_W'(3): op_now = st_q.is_rd ? OP_RX : OP_TX;
            STEP_W'(4): op_now = OP_SLOT;
            default:    op_now = OP_STOP;
        endcase
    end

    assign adv = st_q.run & cmd_done;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.run) begin
            if (wr_req) begin
                st_d.run   = 1'b1;
                st_d.step  = '0;
                st_d.is_rd = 1'b0;
                st_d.addr  = addr_wr;
                st_d.data  = data_in;
            end else if (rd_req) begin
                st_d.run   = 1'b1;
                st_d.step  = '0;
                st_d.is_rd = 1'b1;
                st_d.addr  = addr_rd;
                st_d.data  = '0;
            end
        end else if (cmd_done) begin
            if (st_q.step == S_LAST) begin
                st_d.run  = 1'b0;
                st_d.step = '0;
                st_d.done = 1'b1;
            end else begin
                st_d.step = st_q.step + STEP_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cmd_byte = '0;
        if (st_q.step == S_ADDR) begin
            cmd_byte = st_q.addr;
        end else if (st_q.step == S_BODY && !st_q.is_rd) begin
            cmd_byte = st_q.data;
        end
    end

    assign cmd_valid = st_q.run;
    assign cmd_op    = op_now;
    assign busy      = st_q.run;
    assign done      = st_q.done;
    assign rx_take   = adv & st_q.is_rd & (st_q.step == S_BODY);
    assign fin_rd    = adv & st_q.is_rd & (st_q.step == S_LAST);

endmodule

// File: rtl/iox_rx_capture.sv
module iox_rx_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_take,
    input  logic              fin_rd,
    input  logic [DATA_W-1:0] rx_byte,
    output logic [DATA_W-1:0] rd_pat
);

    typedef struct packed {
        logic [DATA_W-1:0] stage;
        logic [DATA_W-1:0] pat;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (rx_take) begin
            cap_d.stage = rx_byte;
        end
        if (fin_rd) begin
            cap_d.pat = cap_q.stage;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rd_pat = cap_q.pat;

endmodule

// File: rtl/iox_seq.sv
module iox_seq
    import iox_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned STRAP_W = 3,
    parameter int unsigned GROUP_W = 4,
    parameter logic [GROUP_W-1:0] GROUP_CODE = 4'b0100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap,
    input  logic [DATA_W-1:0]  wr_pat,
    input  logic [DATA_W-1:0]  in_mask,
    input  logic               wr_req,
    input  logic               rd_req,
    output logic [DATA_W-1:0]  rd_pat,
    output logic               busy,
    output logic               done,
    output logic               cmd_valid,
    output logic [OP_W-1:0]    cmd_op,
    output logic [DATA_W-1:0]  cmd_byte,
    input  logic               cmd_done,
    input  logic [DATA_W-1:0]  rx_byte,
    input  logic               slot_ack
);

    logic [DATA_W-1:0] addr_wr;
    logic [DATA_W-1:0] addr_rd;
    logic [DATA_W-1:0] data_w;
    logic              rx_take;
    logic              fin_rd;
    logic              ack_unused;

    assign ack_unused = slot_ack;

    iox_frame_builder #(
        .DATA_W     (DATA_W),
        .STRAP_W    (STRAP_W),
        .GROUP_W    (GROUP_W),
        .GROUP_CODE (GROUP_CODE)
    ) u_frame (
        .strap    (strap),
        .pat      (wr_pat),
        .mask     (in_mask),
        .addr_wr  (addr_wr),
        .addr_rd  (addr_rd),
        .data_out (data_w)
    );

    iox_step_ctrl #(
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_req),
        .rd_req    (rd_req),
        .addr_wr   (addr_wr),
        .addr_rd   (addr_rd),
        .data_in   (data_w),
        .cmd_done  (cmd_done),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_byte  (cmd_byte),
        .busy      (busy),
        .done      (done),
        .rx_take   (rx_take),
        .fin_rd    (fin_rd)
    );

    iox_rx_capture #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_take (rx_take),
        .fin_rd  (fin_rd),
        .rx_byte (rx_byte),
        .rd_pat  (rd_pat)
    );

endmodule

// File: rtl/iox_seq_chk.sv
module iox_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic [7:0] cmd_byte,
    input logic       cmd_done,
    input logic [7:0] rd_pat
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R11

    AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy);  // R7

    AST_FIRST_IS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (cmd_valid && cmd_op == 3'd0));  // R2

    AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)));  // R7

    AST_ADDR_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd1 && $past(cmd_op) == 3'd0) |-> (cmd_byte[7:4] == 4'b0100));  // R4

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_done && cmd_op == 3'd4) |=> (!busy && done));  // R11

    AST_RDPAT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_pat) |-> done);  // R9

endmodule

bind iox_seq iox_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_byte  (cmd_byte),
    .cmd_done  (cmd_done),
    .rd_pat    (rd_pat)
);

// File: tb/iox_seq_tb.sv
module iox_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] strap = '0;
    logic [7:0] wr_pat = '0;
    logic [7:0] in_mask = '0;
    logic       wr_req = 1'b0;
    logic       rd_req = 1'b0;
    logic [7:0] rd_pat;
    logic       busy;
    logic       done;
    logic       cmd_valid;
    logic [2:0] cmd_op;
    logic [7:0] cmd_byte;
    logic       cmd_done = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       slot_ack = 1'b0;

    int vecs = 0;
    int bad  = 0;
    logic [7:0] rd_model = 8'h00;

    always #10 clk = ~clk;

    iox_seq u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap     (strap),
        .wr_pat    (wr_pat),
        .in_mask   (in_mask),
        .wr_req    (wr_req),
        .rd_req    (rd_req),
        .rd_pat    (rd_pat),
        .busy      (busy),
        .done      (done),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_byte  (cmd_byte),
        .cmd_done  (cmd_done),
        .rx_byte   (rx_byte),
        .slot_ack  (slot_ack)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vecs++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] exp_op(input int st, input bit rd);
        case (st)
            0: return 3'd0;
            1: return 3'd1;
            2: return 3'd3;
            3: return rd ? 3'd2 : 3'd1;
            4: return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

    task automatic txn(input bit wr, input bit both, input logic [2:0] s,
                       input logic [7:0] p, input logic [7:0] m,
                       input logic [7:0] rx, input int lat);
        logic [7:0] old_pat;
        bit rd;
        logic [7:0] exp_addr;
        logic [7:0] exp_data;
        old_pat  = rd_model;
        rd       = !(wr || both);
        exp_addr = {4'b0100, s, rd};
        exp_data = p | m;
        @(negedge clk);
        strap = s; wr_pat = p; in_mask = m;
        wr_req = wr || both;
        rd_req = !wr || both;
        @(negedge clk);
        wr_req = 1'b0; rd_req = 1'b0;
        chk(busy == 1'b1, "R10 busy after request", busy, 1);
        for (int st = 0; st < 6; st++) begin
            chk(cmd_valid == 1'b1, "R7 cmd_valid", cmd_valid, 1);
            chk(cmd_op == exp_op(st, rd), rd ? "R3 read op order" : "R2 write op order",
                cmd_op, exp_op(st, rd));
            if (st == 1) chk(cmd_byte == exp_addr, "R4 address byte", cmd_byte, exp_addr);
            if (st == 3 && !rd) chk(cmd_byte == exp_data, "R5 data byte", cmd_byte, exp_data);
            if (st == 4) chk(rd_pat == old_pat, "R9 rd_pat held mid transaction", rd_pat, old_pat);
            if (st == 2) begin
                // R6 / R10 / R8 disturbance while busy
                wr_req = 1'b1; rd_req = 1'b1;
                strap = ~s; wr_pat = ~p; in_mask = ~m;
                slot_ack = ~slot_ack;
            end
            for (int w = 0; w < lat; w++) begin
                @(negedge clk);
                slot_ack = ~slot_ack;
            end
            if (lat > 0)
                chk(cmd_valid && cmd_op == exp_op(st, rd), "R7 command held", cmd_op, exp_op(st, rd));
            wr_req = 1'b0; rd_req = 1'b0;
            cmd_done = 1'b1;
            if (st == 3 && rd) rx_byte = rx;
            @(negedge clk);
            cmd_done = 1'b0;
            rx_byte = ~rx;
            if (st == 3 && !rd)
                chk(cmd_byte != exp_data || exp_data == 8'h00, "R6 bytes latched", cmd_byte, 0);
        end
        if (rd) rd_model = rx;
        chk(busy == 1'b0, "R11 busy drops", busy, 0);
        chk(done == 1'b1, "R11 done pulse", done, 1);
        chk(rd_pat == rd_model, "R9 rd_pat at done", rd_pat, rd_model);
        @(negedge clk);
        chk(done == 1'b0, "R11 done one cycle", done, 0);
        chk(busy == 1'b0, "R10 no restart from ignored request", busy, 0);
        chk(rd_pat == rd_model, "R9 rd_pat kept", rd_pat, rd_model);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy reset", busy, 0);
        chk(done == 1'b0, "R1 done reset", done, 0);
        chk(cmd_valid == 1'b0, "R1 cmd_valid reset", cmd_valid, 0);
        chk(rd_pat == 8'h00, "R1 rd_pat reset", rd_pat, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: completion while idle is ignored
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
        chk(busy == 1'b0 && cmd_valid == 1'b0, "R7 idle cmd_done ignored", busy, 0);
        // R8: acknowledge level has no effect while idle
        slot_ack = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R8 slot_ack idle", busy, 0);
        for (int s = 0; s < 8; s++) begin
            for (int k = 0; k < 16; k++) begin
                txn(1'b1, 1'b0, 3'(s), 8'(k * 17 + s * 3), 8'((k * 53) ^ (s << 5)),
                    8'h00, (k + s) % 3);
                txn(1'b0, 1'b0, 3'(s), 8'(k * 11), 8'(k * 7),
                    8'(k * 29 + s * 7 + 1), (k + 2 * s) % 3);
            end
        end
        // R10: simultaneous requests pick the write
        txn(1'b0, 1'b1, 3'd5, 8'h3C, 8'h81, 8'h55, 1);
        // R5 boundary masks
        txn(1'b1, 1'b0, 3'd7, 8'h00, 8'hFF, 8'h00, 0);
        txn(1'b1, 1'b0, 3'd0, 8'hA5, 8'h00, 8'h00, 2);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

endmodule